// File: doc/BRIEF.md
# Multi-Input Stream Merge Arbiter

This block joins several valid/ready input streams into one output stream. Each input carries a payload word and an end-of-burst flag. The output carries the same fields, taken from the input that holds the grant. Two parameters set the behaviour, and each is chosen on its own. The first is the grant policy: lowest index wins, rotating fair share, or strict turn order. The second is the hold policy: no hold, hold until one transfer completes, or hold until a transfer marked end-of-burst completes. The block also reports the granted input, both as a binary index and as a one-hot vector.

The output path has no registers, so `out_valid` follows the inputs in the same cycle. The block keeps only a small amount of state: a turn pointer for the rotating and turn-order policies, and a hold register for the two holding modes. A word moves only in a cycle where `out_valid` and `out_ready` are both high. Back-pressure passes straight through. The granted input sees `out_ready` on its own ready line, and every other input sees ready low. A source must keep its valid and payload steady until it is accepted. When holding is off, the grant may move to another input while the output is stalled.

Parameter encodings: `POLICY` is 0 for fixed priority, 1 for round robin and 2 for turn order. `LOCK` is 0 for no hold, 1 for hold per transfer and 2 for hold per burst. Input `i` uses bits `[i*DATA_W +: DATA_W]` of `in_data`, bit `i` of `in_valid`, bit `i` of `in_ready` and bit `i` of `in_last`.

Top module: `stream_merge_arb`

## Requirements
- R1: A transfer occurs only in a cycle with `out_valid` and `out_ready` both high. While `out_valid` is high, `out_data` and `out_last` equal the payload and last flag of the input named by `grant_idx`.
- R2: `in_ready` is high only on the granted input, and only while `out_valid` and `out_ready` are both high. All other bits of `in_ready` are low.
- R3: With `POLICY`=0 and no hold active, the lowest-numbered valid input is granted.
- R4: With `POLICY`=1 and no hold active, the grant goes to the first valid input at or after the turn pointer, scanning upward and wrapping. The pointer moves to the winner plus one (mod N) only when a transfer completes. With `LOCK`=2, the transfer must also carry last.
- R5: With `POLICY`=2, only the input at the turn pointer can be granted, even when other inputs are valid. The pointer advances by one and wraps after each completed transfer. With `LOCK`=2, the transfer must also carry last.
- R6: With `LOCK`=0, the grant is chosen afresh every cycle. It may move away from a valid input that is still stalled.
- R7: With `LOCK`=1, if `out_valid` is high and no transfer completes, the next cycle keeps the same `grant_idx`. The hold is released by a completed transfer.
- R8: With `LOCK`=2, the grant stays on the same input until a transfer with `out_last` high completes.
- R9: While `out_valid` is high, `grant_oh` has exactly one bit set, the bit at `grant_idx`. While `out_valid` is low, `grant_oh` is zero.
- R10: Reset is synchronous and active high. It clears the turn pointer to input 0 and releases any hold. During reset with no input valid, `out_valid`, `grant_oh` and `in_ready` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | NUM_PORTS | Per-input valid |
| in_ready | output | NUM_PORTS | Per-input ready |
| in_data | input | NUM_PORTS*DATA_W | Packed input payloads, input i at [i*DATA_W +: DATA_W] |
| in_last | input | NUM_PORTS | Per-input end-of-burst flag |
| out_valid | output | 1 | Output valid |
| out_ready | input | 1 | Output ready from the consumer |
| out_data | output | DATA_W | Payload of the granted input |
| out_last | output | 1 | Last flag of the granted input |
| grant_idx | output | IDX_W | Binary index of the granted input |
| grant_oh | output | NUM_PORTS | One-hot grant, zero when out_valid is low |

## Verification
The assertions check the following on every cycle:
- the one-hot grant is consistent with the index;
- ready goes only to the granted valid input;
- fixed priority picks the lowest-numbered valid input;
- the hold policy keeps the grant after a stalled cycle or a non-last beat;
- the turn pointer stays still unless a transfer completes.

Other properties need the bench's scenarios and its cycle-level reference model to show them:
- whether rotation is fair;
- whether turn order refuses a valid input that is not its turn;
- whether the grant moves to a higher-priority input during a stall when holding is off;
- whether the payload reaching the output is the granted input's own.

The bench runs three parameter combinations side by side, so each grant policy and each hold policy is exercised.

// File: rtl/stream_arb_pkg.sv
package stream_arb_pkg;
  localparam int POL_FIXED = 0;
  localparam int POL_RR    = 1;
  localparam int POL_SEQ   = 2;

  localparam int LCK_NONE  = 0;
  localparam int LCK_XACT  = 1;
  localparam int LCK_BURST = 2;
endpackage

// File: rtl/sarb_pick.sv
module sarb_pick
  import stream_arb_pkg::*;
#(
  parameter  int NUM_PORTS = 4,
  parameter  int POLICY    = POL_RR,
  localparam int IDX_W     = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_PORTS-1:0] req,
  input  logic [IDX_W-1:0]     ptr,
  output logic                 any,
  output logic [IDX_W-1:0]     idx
);

  generate
    if (POLICY == POL_FIXED) begin : g_fixed
      // scan from the top so the lowest set bit is the last to be written
      always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = NUM_PORTS - 1; i >= 0; i--) begin
          if (req[i]) begin
            any = 1'b1;
            idx = IDX_W'(i);
          end
        end
      end

      p_fixed_low_r3: assert property (@(posedge clk) disable iff (rst)
        any |-> ((req & ((NUM_PORTS'(1) << idx) - NUM_PORTS'(1))) == '0));
      p_fixed_ptr_r3: assert property (@(posedge clk) disable iff (rst)
        ptr == '0);
    end else if (POLICY == POL_RR) begin : g_rr
      // rotating scan: offset 0 from ptr is written last and wins
      always_comb begin
        int j;
        any = 1'b0;
        idx = '0;
        j   = 0;
        for (int o = NUM_PORTS - 1; o >= 0; o--) begin
          j = int'(ptr) + o;
          if (j >= NUM_PORTS) j = j - NUM_PORTS;
          if (req[j]) begin
            any = 1'b1;
            idx = IDX_W'(j);
          end
        end
      end

      p_rr_valid_r4: assert property (@(posedge clk) disable iff (rst)
        any |-> req[idx]);
      p_rr_ptr_at_r4: assert property (@(posedge clk) disable iff (rst)
        req[ptr] |-> (idx == ptr));
    end else begin : g_seq
      // strict turn order: only the pointed input may win
      always_comb begin
        any = req[ptr];
        idx = ptr;
      end

      p_seq_idle_r5: assert property (@(posedge clk) disable iff (rst)
        !req[ptr] |-> !any);
    end
  endgenerate

endmodule

// File: rtl/sarb_state.sv
module sarb_state
  import stream_arb_pkg::*;
#(
  parameter  int NUM_PORTS = 4,
  parameter  int POLICY    = POL_RR,
  parameter  int LOCK      = LCK_XACT,
  localparam int IDX_W     = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             out_valid,
  input  logic             out_ready,
  input  logic             out_last,
  input  logic [IDX_W-1:0] sel,
  output logic [IDX_W-1:0] ptr,
  output logic             locked,
  output logic [IDX_W-1:0] lock_idx
);

  localparam bit BURST_MODE = (LOCK == LCK_BURST);

  logic fire;
  logic adv;

  assign fire = out_valid & out_ready;
  // an advance event ends a hold and moves the pointer
  assign adv  = fire & (!BURST_MODE | out_last);

  function automatic logic [IDX_W-1:0] wrap_inc(input logic [IDX_W-1:0] v);
    return (int'(v) == NUM_PORTS - 1) ? '0 : v + 1'b1;
  endfunction

  generate
    if (LOCK == LCK_NONE) begin : g_nolock
      assign locked   = 1'b0;
      assign lock_idx = '0;
    end else begin : g_lock
      always_ff @(posedge clk) begin
        if (rst) begin
          locked   <= 1'b0;
          lock_idx <= '0;
        end else if (adv) begin
          locked   <= 1'b0;
        end else if (out_valid) begin
          locked   <= 1'b1;
          lock_idx <= sel;
        end
      end

      if (LOCK == LCK_XACT) begin : g_xact_chk
        p_xact_hold_r7: assert property (@(posedge clk) disable iff (rst)
          (out_valid && !out_ready) |=> (locked && lock_idx == $past(sel)));
      end else begin : g_burst_chk
        p_burst_hold_r8: assert property (@(posedge clk) disable iff (rst)
          (out_valid && !(out_ready && out_last)) |=> (locked && lock_idx == $past(sel)));
      end
    end

    if (POLICY == POL_FIXED) begin : g_ptr_fixed
      assign ptr = '0;
    end else begin : g_ptr_move
      always_ff @(posedge clk) begin
        if (rst) begin
          ptr <= '0;
        end else if (adv) begin
          ptr <= (POLICY == POL_RR) ? wrap_inc(sel) : wrap_inc(ptr);
        end
      end

      p_ptr_idle_r4: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(ptr));
      if (POLICY == POL_SEQ) begin : g_seq_chk
        p_seq_step_r5: assert property (@(posedge clk) disable iff (rst)
          adv |=> (ptr != $past(ptr)));
      end
    end
  endgenerate

  p_sel_range_r9: assert property (@(posedge clk) disable iff (rst)
    int'(sel) < NUM_PORTS);

endmodule

// File: rtl/sarb_mux.sv
module sarb_mux #(
  parameter  int NUM_PORTS = 4,
  parameter  int DATA_W    = 8,
  localparam int IDX_W     = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic [IDX_W-1:0]            sel,
  input  logic [NUM_PORTS*DATA_W-1:0] in_data,
  input  logic [NUM_PORTS-1:0]        in_last,
  output logic [DATA_W-1:0]           out_data,
  output logic                        out_last
);

  logic [DATA_W-1:0] lanes [NUM_PORTS];

  generate
    for (genvar i = 0; i < NUM_PORTS; i++) begin : g_lane
      assign lanes[i] = in_data[i*DATA_W +: DATA_W];
    end
  endgenerate

  assign out_data = lanes[sel];
  assign out_last = in_last[sel];

endmodule

// File: rtl/stream_merge_arb.sv
module stream_merge_arb
  import stream_arb_pkg::*;
#(
  parameter  int NUM_PORTS = 4,
  parameter  int DATA_W    = 8,
  parameter  int POLICY    = POL_RR,
  parameter  int LOCK      = LCK_XACT,
  localparam int IDX_W     = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NUM_PORTS-1:0]        in_valid,
  output logic [NUM_PORTS-1:0]        in_ready,
  input  logic [NUM_PORTS*DATA_W-1:0] in_data,
  input  logic [NUM_PORTS-1:0]        in_last,
  output logic                        out_valid,
  input  logic                        out_ready,
  output logic [DATA_W-1:0]           out_data,
  output logic                        out_last,
  output logic [IDX_W-1:0]            grant_idx,
  output logic [NUM_PORTS-1:0]        grant_oh
);

  logic             pick_any;
  logic [IDX_W-1:0] pick_idx;
  logic [IDX_W-1:0] ptr;
  logic             locked;
  logic [IDX_W-1:0] lock_idx;
  logic [IDX_W-1:0] sel;

  sarb_pick #(.NUM_PORTS(NUM_PORTS), .POLICY(POLICY)) u_pick (
    .clk (clk),
    .rst (rst),
    .req (in_valid),
    .ptr (ptr),
    .any (pick_any),
    .idx (pick_idx)
  );

  assign sel       = locked ? lock_idx : pick_idx;
  assign out_valid = locked ? in_valid[lock_idx] : pick_any;

  sarb_state #(.NUM_PORTS(NUM_PORTS), .POLICY(POLICY), .LOCK(LOCK)) u_state (
    .clk       (clk),
    .rst       (rst),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_last  (out_last),
    .sel       (sel),
    .ptr       (ptr),
    .locked    (locked),
    .lock_idx  (lock_idx)
  );

  sarb_mux #(.NUM_PORTS(NUM_PORTS), .DATA_W(DATA_W)) u_mux (
    .sel      (sel),
    .in_data  (in_data),
    .in_last  (in_last),
    .out_data (out_data),
    .out_last (out_last)
  );

  assign grant_idx = sel;
  assign grant_oh  = out_valid ? (NUM_PORTS'(1) << sel) : '0;
  assign in_ready  = grant_oh & {NUM_PORTS{out_ready}};

  p_oh_single_r9: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ($countones(grant_oh) == 1 && grant_oh[grant_idx]));
  p_oh_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (grant_oh == '0));
  p_ready_only_r2: assert property (@(posedge clk) disable iff (rst)
    (in_ready != '0) |-> (out_ready && in_valid[grant_idx] && $countones(in_ready) == 1));
  p_fire_src_r1: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready) |-> in_ready[grant_idx]);

endmodule

// File: tb/stream_merge_arb_tb.sv
module stream_merge_arb_tb;
  import stream_arb_pkg::*;

  localparam int N  = 4;
  localparam int W  = 8;
  localparam int NC = 3;
  localparam int IW = 2;
  localparam int POL_A [NC] = '{POL_RR, POL_FIXED, POL_SEQ};
  localparam int LCK_A [NC] = '{LCK_XACT, LCK_NONE, LCK_BURST};

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic [N-1:0]   iv    [NC];
  logic [N*W-1:0] idat  [NC];
  logic [N-1:0]   ilast [NC];
  logic           ordy  [NC];
  logic [N-1:0]   ir    [NC];
  logic           ov    [NC];
  logic [W-1:0]   od    [NC];
  logic           ol    [NC];
  logic [IW-1:0]  gi    [NC];
  logic [N-1:0]   goh   [NC];

  generate
    for (genvar k = 0; k < NC; k++) begin : g_cfg
      stream_merge_arb #(.NUM_PORTS(N), .DATA_W(W), .POLICY(POL_A[k]), .LOCK(LCK_A[k])) u_dut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (iv[k]),
        .in_ready  (ir[k]),
        .in_data   (idat[k]),
        .in_last   (ilast[k]),
        .out_valid (ov[k]),
        .out_ready (ordy[k]),
        .out_data  (od[k]),
        .out_last  (ol[k]),
        .grant_idx (gi[k]),
        .grant_oh  (goh[k])
      );
    end
  endgenerate

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;
  int m_ptr  [NC];
  int m_lock [NC];
  int m_lidx [NC];
  logic [N-1:0] acc [NC];

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic int pick(input int pol, input logic [N-1:0] req, input int ptr);
    if (pol == POL_FIXED) begin
      for (int i = 0; i < N; i++) if (req[i]) return i;
      return -1;
    end else if (pol == POL_RR) begin
      for (int o = 0; o < N; o++) if (req[(ptr + o) % N]) return (ptr + o) % N;
      return -1;
    end
    return req[ptr] ? ptr : -1;
  endfunction

  // mode 0: random, mode 1: every new beat valid, mode 2: only top input valid
  task automatic gen(input int mode, input int rmode);
    for (int k = 0; k < NC; k++) begin
      for (int i = 0; i < N; i++) begin
        if (iv[k][i] && !acc[k][i]) continue;
        case (mode)
          0:       iv[k][i] = ($urandom % 3) != 0;
          1:       iv[k][i] = 1'b1;
          default: iv[k][i] = (i == N - 1);
        endcase
        idat[k][i*W +: W] = W'($urandom);
        ilast[k][i]       = ($urandom % 3) == 0;
      end
      ordy[k] = (rmode == 0) ? 1'b0 : (rmode == 1) ? 1'b1 : (($urandom % 4) != 0);
    end
  endtask

  task automatic check_all();
    for (int k = 0; k < NC; k++) begin
      int sel;
      bit e_ov, fire, adv;
      logic [N-1:0] e_oh, e_ir;
      string tag;
      tag = (k == 0) ? "R4 R7" : (k == 1) ? "R3 R6" : "R5 R8";
      if (m_lock[k] != 0) begin
        sel  = m_lidx[k];
        e_ov = iv[k][sel];
      end else begin
        sel  = pick(POL_A[k], iv[k], m_ptr[k]);
        e_ov = (sel >= 0);
        if (sel < 0) sel = 0;
      end
      chk(ov[k] == e_ov, tag, "out_valid", int'(ov[k]), int'(e_ov));
      if (e_ov) begin
        chk(int'(gi[k]) == sel, tag, "grant_idx", int'(gi[k]), sel);
        chk(od[k] == idat[k][sel*W +: W], "R1", "out_data", int'(od[k]), int'(idat[k][sel*W +: W]));
        chk(ol[k] == ilast[k][sel], "R1", "out_last", int'(ol[k]), int'(ilast[k][sel]));
      end
      e_oh = e_ov ? (N'(1) << sel) : '0;
      e_ir = (e_ov && ordy[k]) ? e_oh : '0;
      chk(goh[k] == e_oh, "R9", "grant_oh", int'(goh[k]), int'(e_oh));
      chk(ir[k] == e_ir, "R2", "in_ready", int'(ir[k]), int'(e_ir));
      acc[k] = ir[k];
      fire = e_ov && ordy[k];
      adv  = fire && (LCK_A[k] != LCK_BURST || ilast[k][sel]);
      if (LCK_A[k] != LCK_NONE) begin
        if (adv) m_lock[k] = 0;
        else if (e_ov) begin
          m_lock[k] = 1;
          m_lidx[k] = sel;
        end
      end
      if (adv) begin
        if (POL_A[k] == POL_RR)  m_ptr[k] = (sel + 1) % N;
        if (POL_A[k] == POL_SEQ) m_ptr[k] = (m_ptr[k] + 1) % N;
      end
    end
  endtask

  task automatic step(input int mode, input int rmode);
    @(negedge clk);
    gen(mode, rmode);
    #2;
    check_all();
  endtask

  initial begin
    process::self().srandom(32'd7341);
    for (int k = 0; k < NC; k++) begin
      iv[k] = '0; idat[k] = '0; ilast[k] = '0; ordy[k] = 1'b0; acc[k] = '0;
      m_ptr[k] = 0; m_lock[k] = 0; m_lidx[k] = 0;
    end
    repeat (3) @(negedge clk);
    #2;
    for (int k = 0; k < NC; k++) begin
      chk(ov[k] == 1'b0, "R10", "reset out_valid", int'(ov[k]), 0);
      chk(goh[k] == '0, "R10", "reset grant_oh", int'(goh[k]), 0);
      chk(ir[k] == '0, "R10", "reset in_ready", int'(ir[k]), 0);
    end
    @(negedge clk);
    rst = 1'b0;
    // directed: top input alone and stalled; turn order must wait on input 0
    step(2, 0);
    chk(ov[2] == 1'b0, "R5", "turn-order wait", int'(ov[2]), 0);
    step(2, 0);
    // all inputs raise valid while stalled: no-hold moves to 0, hold keeps 3
    step(1, 0);
    chk(int'(gi[1]) == 0, "R6", "switch during stall", int'(gi[1]), 0);
    chk(int'(gi[0]) == N - 1, "R7", "hold during stall", int'(gi[0]), N - 1);
    step(1, 0);
    repeat (12) step(1, 1);
    repeat (3000) step(0, 2);
    repeat (20) step(1, 2);
    repeat (1000) step(0, 2);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R1 watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule